// File: doc/BRIEF.md
# Circular Stream Writer

This block moves an unframed word stream into a circular region of system memory. Words arrive on a valid/ready input and are staged in a small internal queue. The engine then writes them out as incrementing Wishbone bursts through its master port. Software uses a separate Wishbone register port to set the region bounds and to turn the engine on. It watches the hardware-owned write pointer to see new data, and it moves its own read pointer forward once it has used a block.

Every pointer is a word address. The region runs from the start address up to, but not including, the end address. When a pointer would step onto the end address it goes back to the start address. When a committed word moves the write pointer onto the read pointer, a sticky overflow flag is set. Input is then refused until software clears the flag.

Top module: `ringwr_top`

## Requirements
- R1: After reset, `s_ready` and `m_cyc` are low and every register offset (0 to 7) reads as zero.
- R2: Register word offsets: 0 control (bit 0 = enable), 1 region start, 2 region end (exclusive), 3 write pointer, 4 read pointer, 5 status (bit 0 = overflow); offsets 6 and 7 read zero. Start and end read back as written. A register read or write is acknowledged on the clock edge after the strobe is seen.
- R3: Writing 1 to enable while the engine is off loads both the write and read pointers with the start address.
- R4: `s_ready` is high only while the engine is enabled, overflow is clear and the staging queue is not full.
- R5: A burst starts only when at least `BURST` words are staged. With fewer words queued, `m_cyc` stays low.
- R6: A burst writes staged words in arrival order to consecutive addresses, starting at the write pointer. Every beat except the last carries CTI 3'b010, and the last carries CTI 3'b111.
- R7: The write pointer steps by one for each acknowledged beat and reads back at offset 3. Writes to offset 3 have no effect.
- R8: After the word at end-1 the write pointer returns to the start address. A burst that reaches end-1 stops there with CTI 3'b111, and the rest of the words go in a new burst from the start address. Bus addresses always lie inside the region.
- R9: Overflow (status bit 0) is set when a committed beat moves the write pointer onto the read pointer. While it is set, `s_ready` is low and no new burst starts. A burst already under way finishes.
- R10: Writing 1 to status bit 0 clears overflow. Writing 0 leaves it unchanged.
- R11: While a beat waits for `m_ack`, the master holds its strobe, address, data and CTI steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream word present |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| sl_cyc | input | 1 | Register port cycle |
| sl_stb | input | 1 | Register port strobe |
| sl_we | input | 1 | Register port write enable |
| sl_adr | input | 3 | Register word offset |
| sl_wdat | input | DW | Register write data |
| sl_rdat | output | DW | Register read data |
| sl_ack | output | 1 | Register port acknowledge |
| m_cyc | output | 1 | Master cycle |
| m_stb | output | 1 | Master strobe |
| m_we | output | 1 | Master write enable |
| m_adr | output | AW | Master word address |
| m_dat | output | DW | Master write data |
| m_cti | output | 3 | Master cycle type |
| m_ack | input | 1 | Master acknowledge |

## Verification
A register access gets its acknowledge and read data on the edge after the strobe is seen, so the bench samples them at the falling edge that follows. A burst begins two edges after the word that makes the queue reach `BURST`, and its beats then advance one per acknowledge. The bench therefore waits a fixed number of cycles that covers the whole burst, including inserted wait states, before it checks the logged beats, memory contents and pointers. Overflow and `s_ready` settle on the edge of the beat that collides, so they are read at the next falling edge once the burst has drained.

// File: rtl/ringwr_pkg.sv
package ringwr_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_START = 3'd1,
        REG_END   = 3'd2,
        REG_WPTR  = 3'd3,
        REG_RPTR  = 3'd4,
        REG_STAT  = 3'd5
    } reg_idx_e;

    typedef enum logic {
        M_IDLE,
        M_BURST
    } mst_state_e;

    localparam logic [2:0] CTI_INCR = 3'b010;
    localparam logic [2:0] CTI_LAST = 3'b111;
    localparam logic [2:0] CTI_NONE = 3'b000;

    typedef struct packed {
        logic en;
        logic ovf;
    } ctl_flags_t;

    // next position in the region [lo, hi): steps by one, returns to lo at hi
    function automatic logic [31:0] ring_next(logic [31:0] ptr, logic [31:0] lo, logic [31:0] hi);
        logic [31:0] p1;
        p1 = ptr + 32'd1;
        return (p1 == hi) ? lo : p1;
    endfunction

endpackage

// File: rtl/ringwr_fifo.sv
module ringwr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ix, rd_ix;

    assign full = (count == CW'(DEPTH));
    assign dout = store[rd_ix];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ix <= '0;
            rd_ix <= '0;
            count <= '0;
        end else begin
            if (push) begin
                store[wr_ix] <= din;
                wr_ix        <= wr_ix + 1'b1;
            end
            if (pop) rd_ix <= rd_ix + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ringwr_regs.sv
module ringwr_regs
    import ringwr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sl_cyc,
    input  logic          sl_stb,
    input  logic          sl_we,
    input  logic [2:0]    sl_adr,
    input  logic [DW-1:0] sl_wdat,
    output logic [DW-1:0] sl_rdat,
    output logic          sl_ack,
    input  logic          adv,
    output ctl_flags_t    flags,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] end_q,
    output logic [AW-1:0] wptr_q,
    output logic [AW-1:0] rptr_q
);
    logic          acc;
    logic [AW-1:0] wnext;

    assign acc   = sl_cyc & sl_stb & ~sl_ack;
    assign wnext = AW'(ring_next(32'(wptr_q), 32'(start_q), 32'(end_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_ack  <= 1'b0;
            sl_rdat <= '0;
            flags   <= '0;
            start_q <= '0;
            end_q   <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            sl_ack <= acc;
            if (adv) begin
                wptr_q <= wnext;
                if (wnext == rptr_q) flags.ovf <= 1'b1;
            end
            if (acc && sl_we) begin
                case (reg_idx_e'(sl_adr))
                    REG_CTRL: begin
                        flags.en <= sl_wdat[0];
                        if (sl_wdat[0] && !flags.en) begin
                            wptr_q <= start_q;
                            rptr_q <= start_q;
                        end
                    end
                    REG_START: start_q <= sl_wdat[AW-1:0];
                    REG_END:   end_q   <= sl_wdat[AW-1:0];
                    REG_RPTR:  rptr_q  <= sl_wdat[AW-1:0];
                    REG_STAT:  if (sl_wdat[0]) flags.ovf <= 1'b0;
                    default: ;
                endcase
            end
            if (acc && !sl_we) begin
                case (reg_idx_e'(sl_adr))
                    REG_CTRL:  sl_rdat <= DW'(flags.en);
                    REG_START: sl_rdat <= DW'(start_q);
                    REG_END:   sl_rdat <= DW'(end_q);
                    REG_WPTR:  sl_rdat <= DW'(wptr_q);
                    REG_RPTR:  sl_rdat <= DW'(rptr_q);
                    REG_STAT:  sl_rdat <= DW'(flags.ovf);
                    default:   sl_rdat <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ringwr_master.sv
module ringwr_master
    import ringwr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BURST = 4,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_flags_t    flags,
    input  logic [CW-1:0] fifo_cnt,
    input  logic [DW-1:0] fifo_dout,
    input  logic [AW-1:0] wptr,
    input  logic [AW-1:0] end_adr,
    output logic          beat_done,
    output logic          m_cyc,
    output logic          m_stb,
    output logic          m_we,
    output logic [AW-1:0] m_adr,
    output logic [DW-1:0] m_dat,
    output logic [2:0]    m_cti,
    input  logic          m_ack
);
    localparam int BW = $clog2(BURST+1);

    mst_state_e    state;
    logic [BW-1:0] left;
    logic [BW-1:0] blen;
    logic [AW-1:0] room;

    // a burst never runs past the last word of the region
    always_comb begin
        room = end_adr - wptr;
        if (room < AW'(BURST)) blen = BW'(room);
        else                   blen = BW'(BURST);
        if (blen == '0) blen = BW'(1);
    end

    assign m_cyc     = (state == M_BURST);
    assign m_stb     = m_cyc;
    assign m_we      = m_cyc;
    assign m_adr     = wptr;
    assign m_dat     = fifo_dout;
    assign m_cti     = !m_cyc ? CTI_NONE : ((left == BW'(1)) ? CTI_LAST : CTI_INCR);
    assign beat_done = m_cyc & m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= M_IDLE;
            left  <= '0;
        end else begin
            case (state)
                M_IDLE: begin
                    if (flags.en && !flags.ovf && fifo_cnt >= CW'(BURST)) begin
                        state <= M_BURST;
                        left  <= blen;
                    end
                end
                M_BURST: begin
                    if (m_ack) begin
                        left <= left - 1'b1;
                        if (left == BW'(1)) state <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ringwr_top.sv
module ringwr_top
    import ringwr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BURST = 4,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    output logic          s_ready,
    input  logic          sl_cyc,
    input  logic          sl_stb,
    input  logic          sl_we,
    input  logic [2:0]    sl_adr,
    input  logic [DW-1:0] sl_wdat,
    output logic [DW-1:0] sl_rdat,
    output logic          sl_ack,
    output logic          m_cyc,
    output logic          m_stb,
    output logic          m_we,
    output logic [AW-1:0] m_adr,
    output logic [DW-1:0] m_dat,
    output logic [2:0]    m_cti,
    input  logic          m_ack
);
    localparam int CW = $clog2(DEPTH+1);

    ctl_flags_t    flags;
    logic [AW-1:0] start_q, end_q, wptr_q, rptr_q;
    logic [CW-1:0] fifo_cnt;
    logic [DW-1:0] fifo_dout;
    logic          fifo_full;
    logic          beat_done;
    logic          push;

    assign s_ready = flags.en & ~flags.ovf & ~fifo_full;
    assign push    = s_valid & s_ready;

    ringwr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(s_data), .pop(beat_done),
        .dout(fifo_dout), .full(fifo_full), .count(fifo_cnt)
    );

    ringwr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .sl_cyc(sl_cyc), .sl_stb(sl_stb), .sl_we(sl_we),
        .sl_adr(sl_adr), .sl_wdat(sl_wdat), .sl_rdat(sl_rdat), .sl_ack(sl_ack),
        .adv(beat_done), .flags(flags), .start_q(start_q), .end_q(end_q),
        .wptr_q(wptr_q), .rptr_q(rptr_q)
    );

    ringwr_master #(.AW(AW), .DW(DW), .BURST(BURST), .CW(CW)) u_master (
        .clk(clk), .rst(rst), .flags(flags), .fifo_cnt(fifo_cnt), .fifo_dout(fifo_dout),
        .wptr(wptr_q), .end_adr(end_q), .beat_done(beat_done),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_dat(m_dat),
        .m_cti(m_cti), .m_ack(m_ack)
    );
endmodule

// File: rtl/ringwr_chk.sv
module ringwr_chk
    import ringwr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BURST = 4,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ovf,
    input logic          m_cyc,
    input logic          m_stb,
    input logic          m_ack,
    input logic [AW-1:0] m_adr,
    input logic [DW-1:0] m_dat,
    input logic [2:0]    m_cti,
    input logic [CW-1:0] fifo_cnt,
    input logic [AW-1:0] start_q,
    input logic [AW-1:0] end_q
);
    // R5
    burst_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(m_cyc) |-> ($past(fifo_cnt) >= CW'(BURST)));

    // R11
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_stb && !m_ack) |=> (m_stb && $stable(m_adr) && $stable(m_dat) && $stable(m_cti)));

    // R6
    addr_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (m_stb && m_ack && m_cti == CTI_INCR) |=> (m_stb && m_adr == $past(m_adr) + AW'(1)));

    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(m_cyc && m_ack));

    // R8
    in_region_chk: assert property (@(posedge clk) disable iff (rst)
        m_cyc |-> (m_adr >= start_q && m_adr < end_q));
endmodule

bind ringwr_top ringwr_chk #(.AW(AW), .DW(DW), .BURST(BURST), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ovf(flags.ovf), .m_cyc(m_cyc), .m_stb(m_stb),
    .m_ack(m_ack), .m_adr(m_adr), .m_dat(m_dat), .m_cti(m_cti),
    .fifo_cnt(fifo_cnt), .start_q(start_q), .end_q(end_q)
);

// File: tb/test_ringwr_top.sv
`timescale 1ns/1ps
module test_ringwr_top;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_valid = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          s_ready;
    logic          sl_cyc = 1'b0, sl_stb = 1'b0, sl_we = 1'b0;
    logic [2:0]    sl_adr = '0;
    logic [DW-1:0] sl_wdat = '0;
    logic [DW-1:0] sl_rdat;
    logic          sl_ack;
    logic          m_cyc, m_stb, m_we;
    logic [AW-1:0] m_adr;
    logic [DW-1:0] m_dat;
    logic [2:0]    m_cti;
    logic          m_ack;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ringwr_top #(.AW(AW), .DW(DW), .BURST(4), .DEPTH(8)) i_ringwr_top (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .sl_cyc(sl_cyc), .sl_stb(sl_stb), .sl_we(sl_we), .sl_adr(sl_adr),
        .sl_wdat(sl_wdat), .sl_rdat(sl_rdat), .sl_ack(sl_ack),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_dat(m_dat),
        .m_cti(m_cti), .m_ack(m_ack)
    );

    // memory model with optional alternate-cycle wait states
    logic          slow_ack = 1'b0;
    logic          phase = 1'b0;
    logic [DW-1:0] mem   [32];
    logic [AW-1:0] log_adr [64];
    logic [2:0]    log_cti [64];
    int            nlog = 0;

    assign m_ack = m_cyc & m_stb & (!slow_ack | phase);

    always @(posedge clk) begin
        phase <= rst ? 1'b0 : ~phase;
        if (m_cyc && m_stb && m_ack) begin
            if (!m_we) begin
                n_chk  <= n_chk + 1;
                n_fail <= n_fail + 1;
                $display("FAIL R6: m_we actual 0 expected 1");
            end
            mem[m_adr[4:0]]   <= m_dat;
            log_adr[nlog % 64] <= m_adr;
            log_cti[nlog % 64] <= m_cti;
            nlog <= nlog + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sl_cyc = 1'b1; sl_stb = 1'b1; sl_we = 1'b1; sl_adr = a; sl_wdat = d;
        @(negedge clk);
        while (!sl_ack) @(negedge clk);
        sl_cyc = 1'b0; sl_stb = 1'b0; sl_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        sl_cyc = 1'b1; sl_stb = 1'b1; sl_we = 1'b0; sl_adr = a;
        @(negedge clk);
        while (!sl_ack) @(negedge clk);
        d = sl_rdat;
        sl_cyc = 1'b0; sl_stb = 1'b0;
    endtask

    task automatic push_word(input logic [DW-1:0] d);
        @(negedge clk);
        s_valid = 1'b1; s_data = d;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        #1 s_valid = 1'b0;
    endtask

    task automatic check_beat(input string req, input int idx, input logic [AW-1:0] adr, input logic [2:0] cti);
        check(req, 32'(log_adr[idx % 64]), 32'(adr));
        check(req, 32'(log_cti[idx % 64]), 32'(cti));
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        check("R1 s_ready", 32'(s_ready), 0);
        check("R1 m_cyc", 32'(m_cyc), 0);
        for (int i = 0; i < 8; i++) begin
            reg_rd(3'(i), v);
            check("R1 reg", v, 0);
        end
    endtask

    task automatic t_setup;
        logic [DW-1:0] v;
        reg_wr(3'd1, 32'd8);
        reg_wr(3'd2, 32'd18);
        reg_rd(3'd1, v); check("R2 start", v, 8);
        reg_rd(3'd2, v); check("R2 end", v, 18);
        reg_wr(3'd0, 32'd1);
        reg_rd(3'd0, v); check("R2 ctrl", v, 1);
        reg_rd(3'd3, v); check("R3 wptr", v, 8);
        reg_rd(3'd4, v); check("R3 rptr", v, 8);
        reg_rd(3'd6, v); check("R2 unmapped", v, 0);
        @(negedge clk); check("R4 ready on", 32'(s_ready), 1);
    endtask

    task automatic t_first_burst;
        logic [DW-1:0] v;
        int base;
        base = nlog;
        for (int i = 0; i < 3; i++) push_word(32'hA000_0000 + 32'(i));
        repeat (5) @(negedge clk);
        check("R5 no burst", 32'(m_cyc), 0);
        check("R5 no beats", 32'(nlog - base), 0);
        push_word(32'hA000_0003);
        repeat (12) @(negedge clk);
        check("R6 beats", 32'(nlog - base), 4);
        for (int i = 0; i < 4; i++) begin
            check_beat("R6 beat", base + i, AW'(8 + i), (i == 3) ? 3'b111 : 3'b010);
            check("R6 data", mem[8 + i], 32'hA000_0000 + 32'(i));
        end
        reg_rd(3'd3, v); check("R7 wptr", v, 12);
        reg_wr(3'd3, 32'd5);
        reg_rd(3'd3, v); check("R7 wptr ro", v, 12);
    endtask

    task automatic t_wait_states;
        logic [DW-1:0] v;
        int base;
        base = nlog;
        slow_ack = 1'b1;
        for (int i = 0; i < 4; i++) push_word(32'hB000_0000 + 32'(i));
        repeat (20) @(negedge clk);
        slow_ack = 1'b0;
        check("R11 beats", 32'(nlog - base), 4);
        for (int i = 0; i < 4; i++) begin
            check_beat("R11 beat", base + i, AW'(12 + i), (i == 3) ? 3'b111 : 3'b010);
            check("R11 data", mem[12 + i], 32'hB000_0000 + 32'(i));
        end
        reg_rd(3'd3, v); check("R7 wptr", v, 16);
    endtask

    task automatic t_wrap;
        logic [DW-1:0] v;
        int base;
        base = nlog;
        reg_wr(3'd4, 32'd14);
        reg_rd(3'd4, v); check("R2 rptr", v, 14);
        for (int i = 0; i < 4; i++) push_word(32'hC000_0000 + 32'(i));
        repeat (10) @(negedge clk);
        check("R8 short burst", 32'(nlog - base), 2);
        check_beat("R8 beat", base, 16, 3'b010);
        check_beat("R8 beat", base + 1, 17, 3'b111);
        reg_rd(3'd3, v); check("R8 wptr wrap", v, 8);
        for (int i = 4; i < 6; i++) push_word(32'hC000_0000 + 32'(i));
        repeat (12) @(negedge clk);
        check("R8 beats", 32'(nlog - base), 6);
        for (int i = 0; i < 4; i++)
            check_beat("R8 beat", base + 2 + i, AW'(8 + i), (i == 3) ? 3'b111 : 3'b010);
        check("R8 data", mem[16], 32'hC000_0000);
        check("R8 data", mem[17], 32'hC000_0001);
        check("R8 data", mem[8],  32'hC000_0002);
        check("R8 data", mem[11], 32'hC000_0005);
        reg_rd(3'd3, v); check("R7 wptr", v, 12);
        reg_rd(3'd5, v); check("R9 no ovf", v, 0);
    endtask

    task automatic t_overflow;
        logic [DW-1:0] v;
        int base;
        base = nlog;
        for (int i = 0; i < 4; i++) push_word(32'hD000_0000 + 32'(i));
        repeat (12) @(negedge clk);
        check("R9 burst finishes", 32'(nlog - base), 4);
        reg_rd(3'd5, v); check("R9 ovf set", v, 1);
        check("R9 ready low", 32'(s_ready), 0);
        reg_rd(3'd3, v); check("R9 wptr", v, 16);
        s_valid = 1'b1; s_data = 32'hDEAD_0000;
        repeat (6) @(negedge clk);
        check("R9 still blocked", 32'(s_ready), 0);
        check("R9 no new burst", 32'(m_cyc), 0);
        s_valid = 1'b0;
        reg_wr(3'd5, 32'd0);
        reg_rd(3'd5, v); check("R10 write 0 keeps", v, 1);
        check("R10 ready low", 32'(s_ready), 0);
        reg_wr(3'd5, 32'd1);
        reg_rd(3'd5, v); check("R10 cleared", v, 0);
        check("R10 ready back", 32'(s_ready), 1);
    endtask

    task automatic t_reenable;
        logic [DW-1:0] v;
        reg_wr(3'd0, 32'd0);
        @(negedge clk); check("R4 ready off", 32'(s_ready), 0);
        reg_rd(3'd0, v); check("R2 ctrl off", v, 0);
        reg_wr(3'd0, 32'd1);
        reg_rd(3'd3, v); check("R3 wptr reload", v, 8);
        reg_rd(3'd4, v); check("R3 rptr reload", v, 8);
        @(negedge clk); check("R4 ready on", 32'(s_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup();
        t_first_burst();
        t_wait_states();
        t_wrap();
        t_overflow();
        t_reenable();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule